// File: doc/BRIEF.md
# Sequential GF(2^8) Multiplicative Inverter

This block returns the multiplicative inverse of a field element in GF(2^M), written in the polynomial basis given by a configurable reduction polynomial. Fermat's theorem gives A^(2^M-1) = 1 for every nonzero A, so the inverse is A^(2^M-2), which equals the square of A^(2^(M-1)-1). The block builds that power with an addition chain of the Itoh-Tsujii kind. The chain is steered by the binary digits of M-1. It keeps a running value A^(2^k-1). For each digit below the leading one it doubles k, which takes k squarings and one multiply. When the digit is set it then adds one to k, which takes one squaring and one multiply by A. A last squaring finishes the power.

One combinational multiplier and one combinational squarer are shared across the whole chain. Each clock cycle performs exactly one squaring or one multiply. With the defaults (M = 8, polynomial 0x11B) the chain uses 7 squarings and 4 multiplies, so a result appears 11 cycles after the operand is accepted. A zero operand comes out of the same chain as zero.

Operands enter over a valid/ready port and results leave over a valid/ready port. An operand transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. A result is offered with `out_valid` and stays unchanged until a clock edge where `out_ready` is also high. The block then returns to idle, so a low `out_ready` holds back the next operand. The block holds one operation at a time.

Top module: `itinv_inverter`

## Requirements
- R1: For every nonzero operand A, the result R satisfies A·R = 1 in GF(2^M) reduced by POLY. Bit i of a value is the coefficient of x^i.
- R2: An operand of zero yields a result of zero.
- R3: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 only when no operation is in progress and no result is waiting. It falls on the edge that accepts an operand.
- R4: `out_valid` rises exactly LAT cycles after the accepting edge. LAT = (M-1) + len(M-1) + wt(M-1) - 2, which is 11 for M = 8.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. After an edge with both at 1, `out_valid` is 0 and `in_ready` is 1.
- R6: `in_valid` and `in_data` have no effect while `in_ready` is 0. The result still belongs to the operand that was accepted.
- R7: The reduction polynomial is the parameter POLY (M+1 bits, top bit set). An instance built with 0x11D satisfies R1 in that field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_data | input | M | Operand in polynomial basis |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | M | Inverse of the accepted operand |

## Verification
The hardest case to reach from the ports is an operand change while the chain is running. Every intermediate power is kept in registers, and a leak of a new operand into the final multiplies would corrupt only some results. To reach it, the stimulus keeps `in_valid` high with scrambled data through the whole computation and through held-off results. It does this over every field element and over random operands, then compares each result with an inverse found by brute-force search in the bench. A second instance built on another polynomial runs in lockstep, which shows that the reduction follows the parameter.

// File: rtl/itinv_pkg.sv
package itinv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SQR  = 2'd1,
    ST_MUL  = 2'd2,
    ST_DONE = 2'd3
  } itinv_state_e;

  // Cycles from operand acceptance to result: squarings plus multiplies.
  function automatic int itinv_latency(input int m);
    int n, len, wt;
    n = m - 1;
    len = 0;
    wt = 0;
    while (n > 0) begin
      len = len + 1;
      wt = wt + (n & 1);
      n = n >> 1;
    end
    return (m - 1) + len + wt - 2;
  endfunction

endpackage

// File: rtl/gf_mul.sv
// Combinational GF(2^M) multiplier, MSB-first shift and add with reduction.
module gf_mul #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11B
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);
  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY[M-1:0] : '0);
      if (b[i]) acc = acc ^ a;
    end
    p = acc;
  end
endmodule

// File: rtl/gf_sqr.sv
// Combinational GF(2^M) squarer: spread bits to even positions, then fold
// the high-order terms back with the reduction polynomial.
module gf_sqr #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11B
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] s
);
  localparam int WW = 2 * M - 1;
  localparam logic [WW-1:0] POLY_X = WW'(POLY);

  always_comb begin
    logic [WW-1:0] w;
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = a[i];
    for (int j = WW - 1; j >= M; j--) begin
      if (w[j]) w = w ^ (POLY_X << (j - M));
    end
    s = w[M-1:0];
  end
endmodule

// File: rtl/itinv_inverter.sv
module itinv_inverter #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_data
);
  import itinv_pkg::*;

  localparam int LEN = $clog2(M);          // bit length of M-1
  localparam int KW  = $clog2(M) + 1;      // holds k up to M-1
  localparam int PW  = $clog2(LEN) + 1;    // holds remaining chain digits
  localparam logic [31:0] EXPV = 32'(M - 1);

  itinv_state_e state;
  logic [M-1:0]  a_q, acc, cur, res;
  logic [KW-1:0] k, cnt;
  logic [PW-1:0] pos;
  logic          pend, sel_a, fin;

  logic [M-1:0]  sq_out, mul_b, mul_out;

  assign mul_b = sel_a ? a_q : acc;

  gf_sqr #(.M(M), .POLY(POLY)) u_sqr (.a(cur), .s(sq_out));
  gf_mul #(.M(M), .POLY(POLY)) u_mul (.a(cur), .b(mul_b), .p(mul_out));

  // Chain planner: chooses the next squaring group from the position in M-1.
  logic          pl_pend;
  logic [PW-1:0] pl_pos;
  logic [KW-1:0] pl_k;
  logic [KW-1:0] nx_cnt;
  logic [PW-1:0] nx_pos;
  logic          nx_pend, nx_sel, nx_fin;

  always_comb begin
    if (state == ST_MUL) begin
      pl_pend = pend;
      pl_pos  = pos;
      pl_k    = sel_a ? k + KW'(1) : KW'(k << 1);
    end else begin
      pl_pend = 1'b0;
      pl_pos  = PW'(LEN - 1);
      pl_k    = KW'(1);
    end
    nx_cnt  = KW'(1);
    nx_pos  = pl_pos;
    nx_pend = 1'b0;
    nx_sel  = 1'b0;
    nx_fin  = 1'b0;
    if (pl_pend) begin
      nx_sel = 1'b1;                       // increment step: square once, times A
    end else if (pl_pos != '0) begin
      nx_cnt  = pl_k;                      // doubling step: k squarings, times acc
      nx_pend = EXPV[pl_pos - PW'(1)];
      nx_pos  = pl_pos - PW'(1);
    end else begin
      nx_fin = 1'b1;                       // closing squaring
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      a_q   <= '0;
      acc   <= '0;
      cur   <= '0;
      res   <= '0;
      k     <= '0;
      cnt   <= '0;
      pos   <= '0;
      pend  <= 1'b0;
      sel_a <= 1'b0;
      fin   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          a_q   <= in_data;
          acc   <= in_data;
          cur   <= in_data;
          k     <= pl_k;
          cnt   <= nx_cnt;
          pos   <= nx_pos;
          pend  <= nx_pend;
          sel_a <= nx_sel;
          fin   <= nx_fin;
          state <= ST_SQR;
        end
        ST_SQR: begin
          cur <= sq_out;
          if (cnt == KW'(1)) begin
            if (fin) begin
              res   <= sq_out;
              state <= ST_DONE;
            end else begin
              state <= ST_MUL;
            end
          end else begin
            cnt <= cnt - KW'(1);
          end
        end
        ST_MUL: begin
          acc   <= mul_out;
          cur   <= mul_out;
          k     <= pl_k;
          cnt   <= nx_cnt;
          pos   <= nx_pos;
          pend  <= nx_pend;
          sel_a <= nx_sel;
          fin   <= nx_fin;
          state <= ST_SQR;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_data  = res;

endmodule

// File: rtl/itinv_checker.sv
module itinv_checker #(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11B
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [M-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [M-1:0] out_data
);
  localparam int LAT = itinv_pkg::itinv_latency(M);

  logic [M-1:0] opnd;
  logic [15:0]  busy_cnt;
  logic [M-1:0] prod;

  gf_mul #(.M(M), .POLY(POLY)) u_chk_mul (.a(opnd), .b(out_data), .p(prod));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd     <= '0;
      busy_cnt <= '0;
    end else if (in_valid && in_ready) begin
      opnd     <= in_data;
      busy_cnt <= '0;
    end else if (!in_ready && !out_valid && busy_cnt != 16'hFFFF) begin
      busy_cnt <= busy_cnt + 16'd1;
    end
  end

  AST_INVERSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opnd != '0) |-> (prod == M'(1))); // R1
  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opnd == '0) |-> (out_data == '0)); // R2
  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R3
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (busy_cnt == 16'(LAT))); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready)); // R5
  AST_BUSY_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |=> $stable(opnd)); // R6

endmodule

bind itinv_inverter itinv_checker #(.M(M), .POLY(POLY)) u_itinv_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/tb_itinv_inverter.sv
module tb_itinv_inverter;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 11;
  localparam logic [8:0] POLY_A = 9'h11B;
  localparam logic [8:0] POLY_B = 9'h11D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, in_ready_b, out_valid_b;
  logic [7:0] out_data, out_data_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  itinv_inverter #(.M(8), .POLY(POLY_A)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  itinv_inverter #(.M(8), .POLY(POLY_B)) dut_alt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_data(in_data), .out_valid(out_valid_b), .out_ready(out_ready),
    .out_data(out_data_b));

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [8:0] poly);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int j = 15; j >= 8; j--) if (p[j]) p = p ^ (16'(poly) << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] a, input logic [8:0] poly);
    if (a == 8'h00) return 8'h00;
    for (int x = 1; x < 256; x++)
      if (ref_mul(a, 8'(x), poly) == 8'h01) return 8'(x);
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One operation: present operand, optionally flood junk while busy,
  // hold the result off for 'stall' cycles, then take it.
  task automatic do_op(input logic [7:0] a, input int stall, input bit junk);
    int n;
    logic [7:0] held, exp_a, exp_b;
    string rq;
    exp_a = ref_inv(a, POLY_A);
    exp_b = ref_inv(a, POLY_B);
    rq = (a == 8'h00) ? "R2" : (junk ? "R1/R6" : "R1");
    @(negedge clk);
    check(in_ready == 1'b1, "R3 idle ready", int'(in_ready), 1);
    in_valid = 1'b1;
    in_data  = a;
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R3 ready falls on accept", int'(in_ready), 0);
    in_valid = junk;
    in_data  = ~a;
    n = 0;
    while (!out_valid && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (junk) in_data = 8'($urandom);
    end
    check(n == LAT, "R4 latency", n, LAT);
    check(out_data == exp_a, rq, int'(out_data), int'(exp_a));
    check(out_valid_b && out_data_b == exp_b, "R7 alt polynomial", int'(out_data_b), int'(exp_b));
    held = out_data;
    for (int s = 0; s < stall; s++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid && out_data == held, "R5 hold under back-pressure", int'(out_data), int'(held));
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R5 release to idle", int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R3 reset state",
          int'({in_ready, out_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R3 after reset release",
          int'({in_ready, out_valid}), 2);

    // Directed corners: zero, one, top element, generator-like values.
    do_op(8'h00, 2, 1'b1);
    do_op(8'h01, 0, 1'b0);
    do_op(8'hFF, 3, 1'b1);
    do_op(8'h02, 1, 1'b0);
    do_op(8'h80, 0, 1'b1);

    // Every field element, junk on odd operands.
    for (int v = 0; v < 256; v++) do_op(8'(v), v % 3, v[0]);

    // Random operands with random back-pressure and junk.
    for (int r = 0; r < 200; r++)
      do_op(8'($urandom), int'($urandom % 5), 1'($urandom));

    finish_run();
  end

endmodule